// File: doc/BRIEF.md
# Read-Sequence Store/Recall Command Detector

This block sits beside a 32K x 8 memory port and watches its bus cycles for one of two fixed six-read unlock sequences. Both sequences begin with the same five read addresses. The sixth read decides which command is issued: one address asks for the volatile array to be stored into nonvolatile cells, the other asks for the nonvolatile contents to be recalled. Write cycles never advance a sequence, and the output-enable level does not matter.

When a command is recognised the block raises `access_block` to keep the array idle for a programmable number of clock cycles. A store emits one `store_go` pulse and then holds the block for `STORE_CYC` cycles. A recall runs in two ordered phases: `wipe_go` starts the clearing of the array (`WIPE_CYC` cycles), and `load_go` then starts the copy of nonvolatile data into it (`LOAD_CYC` cycles). A recall only reads the nonvolatile data, so it may be repeated any number of times. Each of the three cycle counts must be at least 2.

The controller states are `S_IDLE`, `S_STORE_KICK`, `S_STORE_WAIT`, `S_WIPE_KICK`, `S_WIPE_WAIT`, `S_LOAD_KICK` and `S_LOAD_WAIT`. A store hit in `S_IDLE` moves to `S_STORE_KICK`, which always moves on to `S_STORE_WAIT`, which returns to `S_IDLE` when its timer expires. A recall hit in `S_IDLE` moves to `S_WIPE_KICK`, then to `S_WIPE_WAIT`, then on expiry to `S_LOAD_KICK`, then to `S_LOAD_WAIT`, and back to `S_IDLE` on expiry. The matcher states `M_NONE` and `M_GOT1` to `M_GOT5` count the prefix reads seen so far. A matching read advances the count by one. A write returns the matcher to `M_NONE`. A mismatching read moves it to `M_GOT1` if the address is 0x0E38, and otherwise to `M_NONE`. In `M_GOT5` a store or recall hit returns it to `M_NONE`.

Top module: `seqcmd_unlock`

## Requirements
- R1: After reset `store_go`, `wipe_go`, `load_go` and `access_block` are all 0, and the matcher holds no partial sequence.
- R2: The reads 0x0E38, 0x31C7, 0x03E0, 0x3C1F and 0x303F, in that order and followed by a read at 0x0FC0, give a single-cycle `store_go` pulse in the clock cycle after the sixth read. `access_block` rises in the same cycle.
- R3: The same five reads followed by a read at 0x0C63 give a single-cycle `wipe_go` pulse in the clock cycle after the sixth read. `access_block` rises in the same cycle.
- R4: `access_block` stays high for exactly `STORE_CYC` cycles after a store, and for exactly `WIPE_CYC + LOAD_CYC` cycles after a recall. Every request pulse falls inside that window.
- R5: `load_go` pulses exactly once, `WIPE_CYC` cycles after `wipe_go`.
- R6: A cycle counts only when `cyc_valid`=1 and `chip_sel`=1. Such a cycle with `wr_en`=1 (a write) never advances the sequence, and it returns the matcher to the start, including at the sixth step.
- R7: The level of `out_en` has no effect. A sequence made of reads with `out_en`=0 still issues its command.
- R8: A read whose address does not match the expected step restarts the matcher. If that address is 0x0E38 it counts as the first step of a new attempt. This also applies at the sixth step.
- R9: Cycles with `cyc_valid`=0 or `chip_sel`=0 are ignored and leave the partial sequence intact.
- R10: Cycles that occur while `access_block` is high are ignored. When the block ends, the matcher starts from the beginning.
- R11: At most one of `store_go`, `wipe_go` and `load_go` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_valid | input | 1 | One memory cycle is presented in this clock |
| chip_sel | input | 1 | Chip enable, active high |
| wr_en | input | 1 | 1 = write cycle, 0 = read cycle |
| out_en | input | 1 | Output enable; has no effect on matching |
| addr | input | 15 | Cycle address |
| store_go | output | 1 | One-cycle request: store the array to nonvolatile cells |
| wipe_go | output | 1 | One-cycle request: clear the array (first recall phase) |
| load_go | output | 1 | One-cycle request: copy nonvolatile data into the array (second recall phase) |
| access_block | output | 1 | The array is disabled for the busy time |

## Verification
Two events can fall on the same read. At the sixth step, an address of 0x0E38 both aborts the pending match and starts a new attempt. The bench sends the prefix with that address as the sixth read, then completes only the remaining five reads, and expects a store. The second overlap is at the end of the busy window: the prefix reads sent while `access_block` is high are dropped, and the restart happens at release. The bench completes such a prefix with a lone tail read after release and expects no request, then sends a full sequence straight after and expects a hit.

// File: rtl/seqcmd_pkg.sv
package seqcmd_pkg;

    parameter int ADDR_W     = 15;
    parameter int PREFIX_LEN = 5;

    localparam logic [ADDR_W-1:0] KEY_STORE  = 15'h0FC0;
    localparam logic [ADDR_W-1:0] KEY_RECALL = 15'h0C63;

    typedef enum logic [2:0] {
        M_NONE, M_GOT1, M_GOT2, M_GOT3, M_GOT4, M_GOT5
    } match_state_t;

    typedef enum logic [2:0] {
        S_IDLE, S_STORE_KICK, S_STORE_WAIT,
        S_WIPE_KICK, S_WIPE_WAIT, S_LOAD_KICK, S_LOAD_WAIT
    } ctl_state_t;

    function automatic logic [ADDR_W-1:0] prefix_key(input int unsigned idx);
        logic [ADDR_W-1:0] k;
        case (idx)
            0:       k = 15'h0E38;
            1:       k = 15'h31C7;
            2:       k = 15'h03E0;
            3:       k = 15'h3C1F;
            default: k = 15'h303F;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/seqcmd_matcher.sv
module seqcmd_matcher
    import seqcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_cyc,
    input  logic              is_wr,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_store,
    output logic              hit_recall
);

    match_state_t cur, nxt, adv, restart;
    logic [ADDR_W-1:0] want;

    always_ff @(posedge clk) begin
        if (!rst_n) cur <= M_NONE;
        else        cur <= nxt;
    end

    // expected key and follow-on state for each step
    always_comb begin
        want = prefix_key(0);
        adv  = M_NONE;
        unique case (cur)
            M_NONE: begin want = prefix_key(0); adv = M_GOT1; end
            M_GOT1: begin want = prefix_key(1); adv = M_GOT2; end
            M_GOT2: begin want = prefix_key(2); adv = M_GOT3; end
            M_GOT3: begin want = prefix_key(3); adv = M_GOT4; end
            M_GOT4: begin want = prefix_key(4); adv = M_GOT5; end
            M_GOT5: begin want = KEY_STORE;     adv = M_NONE; end
            default: begin want = prefix_key(0); adv = M_NONE; end
        endcase
    end

    always_comb restart = (addr == prefix_key(0)) ? M_GOT1 : M_NONE;

    always_comb begin
        nxt        = cur;
        hit_store  = 1'b0;
        hit_recall = 1'b0;
        if (take_cyc) begin
            if (is_wr) begin
                nxt = M_NONE;
            end else if (cur == M_GOT5) begin
                if (addr == KEY_STORE) begin
                    hit_store = 1'b1;
                    nxt       = M_NONE;
                end else if (addr == KEY_RECALL) begin
                    hit_recall = 1'b1;
                    nxt        = M_NONE;
                end else begin
                    nxt = restart;
                end
            end else if (addr == want) begin
                nxt = adv;
            end else begin
                nxt = restart;
            end
        end
    end

endmodule

// File: rtl/seqcmd_timer.sv
module seqcmd_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == CNT_W'(1));

endmodule

// File: rtl/seqcmd_unlock.sv
module seqcmd_unlock
    import seqcmd_pkg::*;
#(
    parameter int STORE_CYC = 20,
    parameter int WIPE_CYC  = 6,
    parameter int LOAD_CYC  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_valid,
    input  logic              chip_sel,
    input  logic              wr_en,
    input  logic              out_en,
    input  logic [ADDR_W-1:0] addr,
    output logic              store_go,
    output logic              wipe_go,
    output logic              load_go,
    output logic              access_block
);

    localparam int MAX_CYC = (STORE_CYC > WIPE_CYC) ?
                             ((STORE_CYC > LOAD_CYC) ? STORE_CYC : LOAD_CYC) :
                             ((WIPE_CYC > LOAD_CYC) ? WIPE_CYC : LOAD_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    ctl_state_t state, nstate;
    logic take_cyc, hit_store, hit_recall;
    logic t_load, t_expired;
    logic [CNT_W-1:0] t_val;

    assign take_cyc = cyc_valid && chip_sel && (state == S_IDLE);

    seqcmd_matcher u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_cyc   (take_cyc),
        .is_wr      (wr_en),
        .addr       (addr),
        .hit_store  (hit_store),
        .hit_recall (hit_recall)
    );

    seqcmd_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_expired)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nstate;
    end

    // transitions
    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE: begin
                if (hit_store)       nstate = S_STORE_KICK;
                else if (hit_recall) nstate = S_WIPE_KICK;
            end
            S_STORE_KICK: nstate = S_STORE_WAIT;
            S_STORE_WAIT: if (t_expired) nstate = S_IDLE;
            S_WIPE_KICK:  nstate = S_WIPE_WAIT;
            S_WIPE_WAIT:  if (t_expired) nstate = S_LOAD_KICK;
            S_LOAD_KICK:  nstate = S_LOAD_WAIT;
            S_LOAD_WAIT:  if (t_expired) nstate = S_IDLE;
            default:      nstate = S_IDLE;
        endcase
    end

    // outputs and timer control
    always_comb begin
        store_go     = 1'b0;
        wipe_go      = 1'b0;
        load_go      = 1'b0;
        access_block = 1'b1;
        t_load       = 1'b0;
        t_val        = '0;
        unique case (state)
            S_IDLE:       access_block = 1'b0;
            S_STORE_KICK: begin
                store_go = 1'b1;
                t_load   = 1'b1;
                t_val    = CNT_W'(STORE_CYC - 1);
            end
            S_WIPE_KICK: begin
                wipe_go = 1'b1;
                t_load  = 1'b1;
                t_val   = CNT_W'(WIPE_CYC - 1);
            end
            S_LOAD_KICK: begin
                load_go = 1'b1;
                t_load  = 1'b1;
                t_val   = CNT_W'(LOAD_CYC - 1);
            end
            S_STORE_WAIT, S_WIPE_WAIT, S_LOAD_WAIT: ;
            default:      access_block = 1'b0;
        endcase
    end

endmodule

// File: rtl/seqcmd_unlock_chk.sv
module seqcmd_unlock_chk #(
    parameter int WIPE_CYC = 6
) (
    input logic clk,
    input logic rst_n,
    input logic cyc_valid,
    input logic chip_sel,
    input logic wr_en,
    input logic out_en,
    input logic store_go,
    input logic wipe_go,
    input logic load_go,
    input logic access_block
);

    localparam int AGE_W = $clog2(WIPE_CYC + 2);
    logic [AGE_W-1:0] wipe_age;

    always_ff @(posedge clk) begin
        if (!rst_n)                 wipe_age <= '0;
        else if (wipe_go)           wipe_age <= AGE_W'(1);
        else if (load_go)           wipe_age <= '0;
        else if (wipe_age != '0 && wipe_age < AGE_W'(WIPE_CYC)) wipe_age <= wipe_age + 1'b1;
    end

    AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({store_go, wipe_go, load_go})); // R11
    AST_STORE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) store_go |=> !store_go); // R2
    AST_WIPE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) wipe_go |=> !wipe_go); // R3
    AST_REQ_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n) (store_go || wipe_go || load_go) |-> access_block); // R4
    AST_BLOCK_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(access_block) |-> (store_go || wipe_go)); // R4
    AST_LOAD_SPACING: assert property (@(posedge clk) disable iff (!rst_n) load_go |-> (wipe_age == AGE_W'(WIPE_CYC))); // R5
    AST_HIT_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n) $rose(access_block) |-> $past(cyc_valid && chip_sel && !wr_en)); // R6
    AST_OE_LOW_HIT: assert property (@(posedge clk) disable iff (!rst_n) (store_go && $past(!out_en)) |-> access_block); // R7

endmodule

bind seqcmd_unlock seqcmd_unlock_chk #(.WIPE_CYC(WIPE_CYC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cyc_valid    (cyc_valid),
    .chip_sel     (chip_sel),
    .wr_en        (wr_en),
    .out_en       (out_en),
    .store_go     (store_go),
    .wipe_go      (wipe_go),
    .load_go      (load_go),
    .access_block (access_block)
);

// File: tb/seqcmd_unlock_test.sv
module seqcmd_unlock_test;

    localparam int STORE_CYC = 20;
    localparam int WIPE_CYC  = 6;
    localparam int LOAD_CYC  = 10;

    localparam logic [14:0] A1 = 15'h0E38, A2 = 15'h31C7, A3 = 15'h03E0,
                            A4 = 15'h3C1F, A5 = 15'h303F;
    localparam logic [14:0] ST = 15'h0FC0, RC = 15'h0C63;

    // row: [20] valid [19] sel [18] wr [17] oe [16:2] addr [1] exp store [0] exp wipe
    localparam int NV = 62;
    localparam logic [20:0] VEC [NV] = '{
        // R2 plain store
        {4'b1101, A1, 2'b00}, {4'b1101, A2, 2'b00}, {4'b1101, A3, 2'b00},
        {4'b1101, A4, 2'b00}, {4'b1101, A5, 2'b00}, {4'b1101, ST, 2'b10},
        // R3 plain recall
        {4'b1101, A1, 2'b00}, {4'b1101, A2, 2'b00}, {4'b1101, A3, 2'b00},
        {4'b1101, A4, 2'b00}, {4'b1101, A5, 2'b00}, {4'b1101, RC, 2'b01},
        // R7 output enable low
        {4'b1100, A1, 2'b00}, {4'b1100, A2, 2'b00}, {4'b1100, A3, 2'b00},
        {4'b1100, A4, 2'b00}, {4'b1100, A5, 2'b00}, {4'b1100, ST, 2'b10},
        // R6 write in the middle
        {4'b1101, A1, 2'b00}, {4'b1101, A2, 2'b00}, {4'b1111, A3, 2'b00},
        {4'b1101, A4, 2'b00}, {4'b1101, A5, 2'b00}, {4'b1101, ST, 2'b00},
        {4'b1101, A1, 2'b00}, {4'b1101, A2, 2'b00}, {4'b1101, A3, 2'b00},
        {4'b1101, A4, 2'b00}, {4'b1101, A5, 2'b00}, {4'b1101, RC, 2'b01},
        // R8 mismatch equal to first key restarts at step one
        {4'b1101, A1, 2'b00}, {4'b1101, A2, 2'b00}, {4'b1101, A1, 2'b00},
        {4'b1101, A2, 2'b00}, {4'b1101, A3, 2'b00}, {4'b1101, A4, 2'b00},
        {4'b1101, A5, 2'b00}, {4'b1101, ST, 2'b10},
        // R9 deselected and invalid cycles keep the partial sequence
        {4'b1101, A1, 2'b00}, {4'b1101, A2, 2'b00}, {4'b1001, 15'h1234, 2'b00},
        {4'b0101, 15'h5555, 2'b00}, {4'b1011, 15'h2222, 2'b00},
        {4'b1101, A3, 2'b00}, {4'b1101, A4, 2'b00}, {4'b1101, A5, 2'b00},
        {4'b1101, RC, 2'b01},
        // R8 wrong sixth read at first key starts a new attempt
        {4'b1101, A1, 2'b00}, {4'b1101, A2, 2'b00}, {4'b1101, A3, 2'b00},
        {4'b1101, A4, 2'b00}, {4'b1101, A5, 2'b00}, {4'b1101, A1, 2'b00},
        {4'b1101, A2, 2'b00}, {4'b1101, A3, 2'b00}, {4'b1101, A4, 2'b00},
        {4'b1101, A5, 2'b00}, {4'b1101, ST, 2'b10},
        // R8 plain mismatch
        {4'b1101, A1, 2'b00}, {4'b1101, 15'h0001, 2'b00}, {4'b1101, A2, 2'b00},
        {4'b1101, ST, 2'b00}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_valid = 1'b0, chip_sel = 1'b0, wr_en = 1'b0, out_en = 1'b0;
    logic [14:0] addr = '0;
    logic store_go, wipe_go, load_go, access_block;

    int checks = 0;
    int failures = 0;
    int multi_req = 0;

    always #5 clk = ~clk;

    seqcmd_unlock #(.STORE_CYC(STORE_CYC), .WIPE_CYC(WIPE_CYC), .LOAD_CYC(LOAD_CYC)) uut (
        .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .chip_sel(chip_sel),
        .wr_en(wr_en), .out_en(out_en), .addr(addr), .store_go(store_go),
        .wipe_go(wipe_go), .load_go(load_go), .access_block(access_block)
    );

    // R11 monitor
    always @(negedge clk)
        if (rst_n && (int'(store_go) + int'(wipe_go) + int'(load_go) > 1)) multi_req++;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_cyc(input logic v, input logic s, input logic w, input logic o,
                          input logic [14:0] a);
        cyc_valid = v; chip_sel = s; wr_en = w; out_en = o; addr = a;
        @(posedge clk); #1;
    endtask

    task automatic idle_cyc();
        do_cyc(1'b0, 1'b0, 1'b0, 1'b1, 15'h0);
    endtask

    task automatic send_prefix();
        do_cyc(1, 1, 0, 1, A1); do_cyc(1, 1, 0, 1, A2); do_cyc(1, 1, 0, 1, A3);
        do_cyc(1, 1, 0, 1, A4); do_cyc(1, 1, 0, 1, A5);
    endtask

    task automatic drain();
        for (int i = 0; i < 200 && access_block; i++) idle_cyc();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        int n;
        int load_at;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 store_go", store_go, 0);
        chk("R1 wipe_go", wipe_go, 0);
        chk("R1 load_go", load_go, 0);
        chk("R1 access_block", access_block, 0);
        rst_n = 1'b1;
        idle_cyc();
        // R1 no partial sequence: lone tail after reset gives nothing
        do_cyc(1, 1, 0, 1, ST);
        chk("R1 no stale match", store_go, 0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            do_cyc(VEC[i][20], VEC[i][19], VEC[i][18], VEC[i][17], VEC[i][16:2]);
            chk($sformatf("R2 store row %0d", i), store_go, int'(VEC[i][1]));
            chk($sformatf("R3 wipe row %0d", i), wipe_go, int'(VEC[i][0]));
            if (VEC[i][1] || VEC[i][0]) chk($sformatf("R4 block row %0d", i), access_block, 1);
            drain();
        end

        // R4 store span
        send_prefix();
        do_cyc(1, 1, 0, 1, ST);
        n = access_block ? 1 : 0;
        for (int i = 0; i < 200 && access_block; i++) begin
            idle_cyc();
            if (access_block) n++;
        end
        chk("R4 store span", n, STORE_CYC);

        // R4/R5 recall span and phase spacing
        send_prefix();
        do_cyc(1, 1, 0, 1, RC);
        chk("R3 wipe pulse", wipe_go, 1);
        n = 1;
        load_at = -1;
        for (int i = 0; i < 200 && access_block; i++) begin
            idle_cyc();
            if (load_go) load_at = n;
            if (access_block) n++;
        end
        chk("R5 load offset", load_at, WIPE_CYC);
        chk("R4 recall span", n, WIPE_CYC + LOAD_CYC);

        // R6 write at the sixth step
        send_prefix();
        do_cyc(1, 1, 1, 1, ST);
        chk("R6 write tail store", store_go, 0);
        chk("R6 write tail block", access_block, 0);
        do_cyc(1, 1, 0, 1, ST);
        chk("R6 matcher reset after write", store_go, 0);

        // R10 reads during the busy window are ignored
        send_prefix();
        do_cyc(1, 1, 0, 1, ST);
        send_prefix();
        drain();
        do_cyc(1, 1, 0, 1, ST);
        chk("R10 busy prefix dropped", store_go, 0);
        send_prefix();
        do_cyc(1, 1, 0, 1, RC);
        chk("R10 fresh match after release", wipe_go, 1);
        drain();

        chk("R11 request overlap count", multi_req, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule